// File: doc/BRIEF.md
# Secondary Core Launch Register Block

This block is a 32-bit memory-mapped register window of 1 KiB that governs how secondary processor cores leave reset. Software stores a boot entry address, a general control word and a standby flag word in it. When software writes a nonzero value to a core's reset-control register, the block issues a single-cycle start pulse for that core. Along with the pulse it gives the core index, the entry address held at the time of the write, and a fixed privilege level of 3. The core index comes from the register offset.

The remaining per-core and global registers return constant values and discard writes. Any access that misses every defined register, or that is not word aligned, raises a one-cycle bus error flag. The block uses a single-cycle register bus. A request is presented for one clock. Read data, the error flag and start outputs are all registered, so they appear in the cycle after the request.

Top module: `cboot_ctrl`

## Requirements
- R1: While rst_ni is low and after its release, general control holds 0x20, the standby flag holds 0, the entry address holds 0, and rdata_o, err_o, start_o, start_core_o, start_addr_o and start_el_o are 0.
- R2: Read data appears on rdata_o in the cycle after a read request (req_i=1, we_i=0). In a cycle that follows no read request, rdata_o is 0.
- R3: The general control (0x184), standby flag (0x1A0) and entry address (0x1A4) registers accept all 32 bits on write and return them on read.
- R4: Offsets 0x000 and 0x140 read 0x1 and offset 0x144 reads 0x10F. Writes to these offsets change nothing.
- R5: There is one four-register group per core, every 0x40 bytes from 0x40. At +0x0 it reads 0x3, at +0x4 it reads 0 and at +0x8 it reads 0x1. Writes to +0x4 and +0x8 change nothing and start no core.
- R6: A write of a nonzero value to offset 0x40 + 0x40*n produces, in the next cycle, start_o with only bit n set for exactly that one cycle, and start_core_o = n. Back-to-back such writes give back-to-back pulses.
- R7: With a start pulse, start_addr_o equals the entry address register as it stood before the write cycle, and start_el_o equals 3. In every other cycle start_core_o, start_addr_o and start_el_o are 0.
- R8: A write of zero to a core's reset-control register produces no start pulse.
- R9: Offsets 0x1E4, 0x280, 0x284 and 0x288 read 0, discard writes and do not raise err_o.
- R10: An access to any other offset, or to an address whose two low bits are nonzero, reads 0 and discards writes. It raises err_o for exactly the next cycle.
- R11: At most one bit of start_o is set in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 10 | Byte offset within the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| err_o | output | 1 | Out-of-range access flag, one cycle |
| start_o | output | 4 | One-hot start pulse per core |
| start_core_o | output | 2 | Index of the core being started |
| start_addr_o | output | 32 | Entry address for the started core |
| start_el_o | output | 2 | Privilege level for the started core |

## Verification
Start requests are sent to every core, to two cores back to back, and as a write that follows an entry-address update in the very next cycle. The last case shows whether the captured address is the value held before the write cycle. A zero write, and writes to each core's control and status offsets, separate the trigger condition from a plain address match. Reads and writes to unimplemented, out-of-range and misaligned offsets show whether the error flag depends on the kind of miss. Write-then-read sequences on the constant registers, combined with later read-back of the stored words, show that discarded writes leave no trace.

// File: rtl/cboot_pkg.sv
package cboot_pkg;

  localparam logic [31:0] OFF_GLB_RST   = 32'h000;
  localparam logic [31:0] OFF_CORE_BASE = 32'h040;
  localparam int unsigned CORE_STRIDE_LG = 6;
  localparam logic [31:0] OFF_SYS_RST   = 32'h140;
  localparam logic [31:0] OFF_GATE      = 32'h144;
  localparam logic [31:0] OFF_GEN       = 32'h184;
  localparam logic [31:0] OFF_STBY      = 32'h1A0;
  localparam logic [31:0] OFF_ENTRY     = 32'h1A4;
  localparam logic [31:0] OFF_DBG       = 32'h1E4;
  localparam logic [31:0] OFF_CNT_CTL   = 32'h280;
  localparam logic [31:0] OFF_CNT_LO    = 32'h284;
  localparam logic [31:0] OFF_CNT_HI    = 32'h288;

  localparam logic [5:0] SUB_RST  = 6'h00;
  localparam logic [5:0] SUB_CTL  = 6'h04;
  localparam logic [5:0] SUB_STAT = 6'h08;

  localparam logic [31:0] VAL_RELEASED = 32'h1;
  localparam logic [31:0] VAL_CORE_RST = 32'h3;
  localparam logic [31:0] VAL_CORE_ST  = 32'h1;
  localparam logic [31:0] VAL_GATE     = 32'h10F;
  localparam logic [31:0] RST_GEN      = 32'h20;
  localparam logic [31:0] RST_STBY     = 32'h0;
  localparam logic [31:0] RST_ENTRY    = 32'h0;

  typedef enum logic [3:0] {
    RG_OOB,
    RG_GLB_RST,
    RG_SYS_RST,
    RG_GATE,
    RG_CORE_RST,
    RG_CORE_CTL,
    RG_CORE_STAT,
    RG_GEN,
    RG_STBY,
    RG_ENTRY,
    RG_UNIMP
  } region_e;

endpackage

// File: rtl/cboot_decode.sv
module cboot_decode
  import cboot_pkg::*;
#(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned NUM_CORES = 4,
  localparam int unsigned CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output region_e           region_o,
  output logic [CORE_W-1:0] core_o
);

  localparam logic [31:0] CORE_SPAN = 32'(NUM_CORES) << CORE_STRIDE_LG;

  logic [31:0] a32;
  logic [31:0] rel;
  logic        in_core;
  logic [5:0]  sub;

  assign a32     = 32'(addr_i);
  assign rel     = a32 - OFF_CORE_BASE;
  assign in_core = (a32 >= OFF_CORE_BASE) && (rel < CORE_SPAN);
  assign sub     = rel[5:0];
  assign core_o  = rel[CORE_W+CORE_STRIDE_LG-1:CORE_STRIDE_LG];

  always_comb begin
    region_o = RG_OOB;
    if (a32[1:0] == 2'b00) begin
      if (in_core) begin
        unique case (sub)
          SUB_RST:  region_o = RG_CORE_RST;
          SUB_CTL:  region_o = RG_CORE_CTL;
          SUB_STAT: region_o = RG_CORE_STAT;
          default:  region_o = RG_OOB;
        endcase
      end else begin
        unique case (a32)
          OFF_GLB_RST: region_o = RG_GLB_RST;
          OFF_SYS_RST: region_o = RG_SYS_RST;
          OFF_GATE:    region_o = RG_GATE;
          OFF_GEN:     region_o = RG_GEN;
          OFF_STBY:    region_o = RG_STBY;
          OFF_ENTRY:   region_o = RG_ENTRY;
          OFF_DBG,
          OFF_CNT_CTL,
          OFF_CNT_LO,
          OFF_CNT_HI:  region_o = RG_UNIMP;
          default:     region_o = RG_OOB;
        endcase
      end
    end
  end

endmodule

// File: rtl/cboot_store.sv
module cboot_store
  import cboot_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  region_e           region_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] gen_o,
  output logic [DATA_W-1:0] stby_o,
  output logic [DATA_W-1:0] entry_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gen_o   <= DATA_W'(RST_GEN);
      stby_o  <= DATA_W'(RST_STBY);
      entry_o <= DATA_W'(RST_ENTRY);
    end else if (wr_i) begin
      if (region_i == RG_GEN)   gen_o   <= wdata_i;
      if (region_i == RG_STBY)  stby_o  <= wdata_i;
      if (region_i == RG_ENTRY) entry_o <= wdata_i;
    end
  end

endmodule

// File: rtl/cboot_launch.sv
module cboot_launch #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned EL_W      = 2,
  parameter int unsigned START_EL  = 3,
  localparam int unsigned CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 fire_i,
  input  logic [CORE_W-1:0]    core_i,
  input  logic [DATA_W-1:0]    entry_i,
  output logic [NUM_CORES-1:0] start_o,
  output logic [CORE_W-1:0]    core_o,
  output logic [DATA_W-1:0]    addr_o,
  output logic [EL_W-1:0]      el_o
);

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) start_o[c] <= 1'b0;
      else         start_o[c] <= fire_i && (core_i == CORE_W'(c));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      core_o <= '0;
      addr_o <= '0;
      el_o   <= '0;
    end else if (fire_i) begin
      core_o <= core_i;
      addr_o <= entry_i;
      el_o   <= EL_W'(START_EL);
    end else begin
      core_o <= '0;
      addr_o <= '0;
      el_o   <= '0;
    end
  end

endmodule

// File: rtl/cboot_ctrl.sv
module cboot_ctrl
  import cboot_pkg::*;
#(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned EL_W      = 2,
  parameter int unsigned START_EL  = 3,
  localparam int unsigned CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 err_o,
  output logic [NUM_CORES-1:0] start_o,
  output logic [CORE_W-1:0]    start_core_o,
  output logic [DATA_W-1:0]    start_addr_o,
  output logic [EL_W-1:0]      start_el_o
);

  region_e           region;
  logic [CORE_W-1:0] core;
  logic [DATA_W-1:0] gen_q, stby_q, entry_q;
  logic [DATA_W-1:0] rd_mux;
  logic              wr, rd, fire;

  assign wr   = req_i & we_i;
  assign rd   = req_i & ~we_i;
  assign fire = wr & (region == RG_CORE_RST) & (|wdata_i);

  cboot_decode #(
    .ADDR_W   (ADDR_W),
    .NUM_CORES(NUM_CORES)
  ) u_decode (
    .addr_i  (addr_i),
    .region_o(region),
    .core_o  (core)
  );

  cboot_store #(
    .DATA_W(DATA_W)
  ) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr),
    .region_i(region),
    .wdata_i (wdata_i),
    .gen_o   (gen_q),
    .stby_o  (stby_q),
    .entry_o (entry_q)
  );

  cboot_launch #(
    .DATA_W   (DATA_W),
    .NUM_CORES(NUM_CORES),
    .EL_W     (EL_W),
    .START_EL (START_EL)
  ) u_launch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (fire),
    .core_i (core),
    .entry_i(entry_q),
    .start_o(start_o),
    .core_o (start_core_o),
    .addr_o (start_addr_o),
    .el_o   (start_el_o)
  );

  always_comb begin
    unique case (region)
      RG_GLB_RST,
      RG_SYS_RST:   rd_mux = DATA_W'(VAL_RELEASED);
      RG_GATE:      rd_mux = DATA_W'(VAL_GATE);
      RG_CORE_RST:  rd_mux = DATA_W'(VAL_CORE_RST);
      RG_CORE_STAT: rd_mux = DATA_W'(VAL_CORE_ST);
      RG_GEN:       rd_mux = gen_q;
      RG_STBY:      rd_mux = stby_q;
      RG_ENTRY:     rd_mux = entry_q;
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      rdata_o <= rd ? rd_mux : '0;
      err_o   <= req_i && (region == RG_OOB);
    end
  end

endmodule

// File: rtl/cboot_ctrl_chk.sv
module cboot_ctrl_chk #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned EL_W      = 2,
  parameter int unsigned START_EL  = 3
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_i,
  input logic                 we_i,
  input logic [DATA_W-1:0]    wdata_i,
  input logic [DATA_W-1:0]    rdata_o,
  input logic                 err_o,
  input logic [NUM_CORES-1:0] start_o,
  input logic [EL_W-1:0]      start_el_o
);

  AST_START_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(start_o)); // R11

  AST_START_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o != '0) |-> $past(req_i && we_i && (wdata_i != '0))); // R6

  AST_ZERO_WRITE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && (wdata_i == '0)) |=> (start_o == '0)); // R8

  AST_START_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o != '0) |-> (start_el_o == EL_W'(START_EL))); // R7

  AST_ERR_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(req_i)); // R10

  AST_ERR_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (rdata_o == '0)); // R10

  AST_IDLE_RDATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> (rdata_o == '0)); // R2

endmodule

bind cboot_ctrl cboot_ctrl_chk #(
  .DATA_W   (DATA_W),
  .NUM_CORES(NUM_CORES),
  .EL_W     (EL_W),
  .START_EL (START_EL)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .err_o     (err_o),
  .start_o   (start_o),
  .start_el_o(start_el_o)
);

// File: tb/tb_cboot_ctrl.sv
`timescale 1ns/1ps
module tb_cboot_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        err;
  logic [3:0]  start;
  logic [1:0]  score;
  logic [31:0] saddr;
  logic [1:0]  sel;

  int checks = 0;
  int errors = 0;
  int cyc_cnt = 0;

  // reference state
  int unsigned m_gen, m_stby, m_entry;

  always #2 clk = ~clk;

  cboot_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .err_o(err), .start_o(start),
    .start_core_o(score), .start_addr_o(saddr), .start_el_o(sel)
  );

  // 0 oob,1 const1,2 gate,3 core rst,4 core ctl,5 core stat,6 gen,7 stby,8 entry,9 unimp
  function automatic int kind(input int unsigned a);
    if (a % 4 != 0) return 0;
    if (a >= 'h40 && a < 'h140) begin
      case ((a - 'h40) % 'h40)
        0: return 3;
        4: return 4;
        8: return 5;
        default: return 0;
      endcase
    end
    case (a)
      'h000, 'h140: return 1;
      'h144: return 2;
      'h184: return 6;
      'h1A0: return 7;
      'h1A4: return 8;
      'h1E4, 'h280, 'h284, 'h288: return 9;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_gen = 'h20; m_stby = 0; m_entry = 0;
  endtask

  task automatic cyc(input bit rq, input bit w, input int unsigned a,
                     input int unsigned d, input string tag);
    int unsigned e_rd = 0, e_addr = 0;
    int e_start = 0, e_core = 0, e_el = 0;
    bit e_err = 0;
    int k;
    @(negedge clk);
    req = rq; we = w; addr = 10'(a); wdata = d;
    k = kind(a);
    if (rq) begin
      e_err = (k == 0);
      if (!w) begin
        case (k)
          1: e_rd = 1;
          2: e_rd = 'h10F;
          3: e_rd = 3;
          5: e_rd = 1;
          6: e_rd = m_gen;
          7: e_rd = m_stby;
          8: e_rd = m_entry;
          default: e_rd = 0;
        endcase
      end else begin
        if (k == 3 && d != 0) begin
          e_core = (a - 'h40) / 'h40;
          e_start = 1 << e_core;
          e_addr = m_entry;
          e_el = 3;
        end
        if (k == 6) m_gen = d;
        if (k == 7) m_stby = d;
        if (k == 8) m_entry = d;
      end
    end
    @(posedge clk);
    #1;
    chk(tag, "rdata", rdata, e_rd);
    chk(tag, "err", err, e_err);
    chk(tag, "start", start, e_start);
    chk(tag, "start_core", score, e_core);
    chk(tag, "start_addr", saddr, e_addr);
    chk(tag, "start_el", sel, e_el);
    req = 0;
  endtask

  task automatic rd(input int unsigned a, input string tag);
    cyc(1, 0, a, 0, tag);
  endtask
  task automatic wr(input int unsigned a, input int unsigned d, input string tag);
    cyc(1, 1, a, d, tag);
  endtask
  task automatic idle(input string tag);
    cyc(0, 0, 0, 0, tag);
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cyc_cnt);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "rdata in reset", rdata, 0);
    chk("R1", "start in reset", start, 0);
    chk("R1", "err in reset", err, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    idle("R1");
    rd('h184, "R1");
    rd('h1A0, "R1");
    rd('h1A4, "R1");

    // R4 constant registers, writes discarded
    rd('h000, "R4"); rd('h140, "R4"); rd('h144, "R4");
    wr('h000, 'hFFFF_FFFF, "R4"); wr('h140, 0, "R4"); wr('h144, 'h0, "R4");
    rd('h000, "R4"); rd('h140, "R4"); rd('h144, "R4");

    // R5 per-core constants
    for (int c = 0; c < 4; c++) begin
      rd('h40 + c * 'h40, "R5");
      rd('h44 + c * 'h40, "R5");
      rd('h48 + c * 'h40, "R5");
      wr('h44 + c * 'h40, 'h5A5A_0001, "R5");
      wr('h48 + c * 'h40, 'hFFFF_FFFF, "R5");
      rd('h44 + c * 'h40, "R5");
      rd('h48 + c * 'h40, "R5");
    end

    // R3 stored words
    wr('h184, 'hDEAD_BEEF, "R3"); rd('h184, "R3");
    wr('h1A0, 'h0000_0001, "R3"); rd('h1A0, "R3");
    wr('h1A4, 'h8000_0000, "R3"); rd('h1A4, "R3");
    wr('h184, 'h0, "R3"); rd('h184, "R3");
    idle("R2");

    // R6 R7 each core with a distinct entry
    for (int c = 0; c < 4; c++) begin
      wr('h1A4, 'h4000_1000 + c * 'h100, "R7");
      idle("R7");
      wr('h40 + c * 'h40, c + 1, "R6");
      idle("R6");
    end
    // back-to-back starts
    wr('h40 + 2 * 'h40, 'h8000_0000, "R6");
    wr('h40 + 0 * 'h40, 1, "R6");
    idle("R11");
    // entry written then start in next cycle
    wr('h1A4, 'hCAFE_0000, "R7");
    wr('h40 + 3 * 'h40, 7, "R7");
    wr('h1A4, 'h1234_5678, "R7");
    wr('h40 + 1 * 'h40, 2, "R7");
    idle("R7");

    // R8 zero writes
    for (int c = 0; c < 4; c++) wr('h40 + c * 'h40, 0, "R8");
    idle("R8");

    // R9 unimplemented
    wr('h1E4, 'hFFFF_FFFF, "R9"); rd('h1E4, "R9");
    wr('h280, 'h1, "R9"); rd('h280, "R9");
    rd('h284, "R9"); rd('h288, "R9");

    // R10 out-of-range and misaligned
    rd('h3FC, "R10");
    wr('h14C, 'h1, "R10");
    rd('h4C, "R10");
    wr('h185, 'hFFFF, "R10");
    rd('h185, "R10");
    wr('h41, 'h1, "R10");
    idle("R10");
    rd('h184, "R10");
    rd('h1A4, "R10");

    // R1 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    rst_n = 1'b1;
    idle("R1");
    rd('h184, "R1");
    rd('h1A4, "R1");
    wr('h40, 1, "R1");
    idle("R1");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule